// File: doc/BRIEF.md
# Status Register Transfer Unit

This unit serves the execute stage of a 32-bit RISC core. It moves data between a general register and the current program status register in both directions. The encodings it serves sit in the compare/test opcode slots with the flag-setting bit clear. One form copies the status word into a destination register. A second form writes a register into the whole status word. A third form writes only the four condition flags, taking its value from a register or from an already rotated immediate.

The register file delivers the source operand, and the immediate path delivers the rotated immediate. The unit decodes the word and applies user-mode protection, so that a user-mode full write touches only the flags. Malformed words in its opcode slots produce an undefined-instruction pulse instead of any write. All outputs come from one register stage, and one issued word produces one result on the following cycle. Saved status registers are handled elsewhere.

Top module: `psr_xfer_unit`

## Requirements
- R1: A claimed word with bit 21 = 0 (test slot), bits[19:16] = 4'hF, bits[11:0] = 0 and bits[15:12] != 15 is a status read. It asserts `rd_we`, sets `rd_idx` to bits[15:12] and sets `rd_data` to `cur_psr`. No status write enable is set.
- R2: A claimed word with bit 21 = 1, bits[19:12] = 8'h9F and bits[11:4] = 0 is a full write. When `cur_mode` is not user, it asserts both `psr_we_flags` and `psr_we_ctrl` with `psr_wdata` = `reg_opnd`.
- R3: A full write issued while `cur_mode` = 5'b10000 (user) asserts only `psr_we_flags`. In that case `psr_wdata` = {`reg_opnd`[31:28], `cur_psr`[27:0]}, so the control bits are left unchanged.
- R4: A claimed word with bit 21 = 1 and bits[19:12] = 8'h8F is a flags-only write in any mode. Bit 25 = 1 takes the source from `imm_opnd` and bit 25 = 0 from `reg_opnd`. Only `psr_we_flags` is asserted, with `psr_wdata` = {src[31:28], `cur_psr`[27:0]}. The flag positions are N = 31, Z = 30, C = 29 and V = 28.
- R5: A flags-only word with bit 25 = 0 is undefined when bits[3:0] = 15 or bits[11:4] != 0. The immediate form accepts any value in bits[11:0].
- R6: Any other claimed word is undefined. A claimed word has bits[27:26] = 00, bits[24:23] = 10 and bit 20 = 0; bit 21 picks the slot, and bits[31:28] and bit 22 are not examined.
- R7: An undefined word produces `undef_pulse` high for exactly the one result cycle. No write enable is set in that cycle.
- R8: When `issue_vld` is low, or the word is not claimed, every output is zero. `rd_idx` and `rd_data` are zero whenever `rd_we` is low, and `psr_wdata` is zero whenever `psr_we_flags` is low.
- R9: Results appear on the cycle after the issue edge, and all outputs are zero during and immediately after reset.
- R10: `rd_we` is never asserted with `rd_idx` = 15. A status read naming register 15 is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | An instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| reg_opnd | input | 32 | Register operand selected by bits[3:0] |
| imm_opnd | input | 32 | Rotated immediate operand |
| cur_psr | input | 32 | Current status register |
| cur_mode | input | 5 | Current processor mode |
| rd_we | output | 1 | General register write enable |
| rd_idx | output | 4 | Destination register index |
| rd_data | output | 32 | Data for the general register |
| psr_we_flags | output | 1 | Write enable for bits[31:28] |
| psr_we_ctrl | output | 1 | Write enable for bits[27:0] |
| psr_wdata | output | 32 | New status word |
| undef_pulse | output | 1 | Undefined-encoding pulse |

## Verification
A misclassified word shows up on the very next cycle as the wrong enable set. Examples are a write where an undefined pulse was due, or a control-field write in user mode. A wrong merge shows up in that same cycle as `psr_wdata` control bits that differ from the `cur_psr` presented one cycle earlier. The bench sweeps every value of bits[19:12] across both slots, both operand kinds, both mode classes and the boundary values of the low twelve bits. Any such fault therefore surfaces within one result cycle of the offending word.

// File: rtl/psr_xfer_pkg.sv
package psr_xfer_pkg;

   localparam int unsigned INSTR_W = 32;
   localparam int unsigned IDX_W   = 4;
   localparam logic [IDX_W-1:0] PC_IDX = 4'hF;

   // field patterns on bits[19:0]
   localparam logic [19:0] RD_MASK   = 20'hF0FFF;
   localparam logic [19:0] RD_VAL    = 20'hF0000;
   localparam logic [19:0] FULL_MASK = 20'hFFFF0;
   localparam logic [19:0] FULL_VAL  = 20'h9F000;
   localparam logic [19:0] FLAG_MASK = 20'hFF000;
   localparam logic [19:0] FLAG_VAL  = 20'h8F000;

   typedef enum logic [2:0] {
      XK_NONE,
      XK_READ,
      XK_FULL,
      XK_FLAG,
      XK_UNDEF
   } xfer_kind_e;

   typedef struct packed {
      xfer_kind_e       kind;
      logic [IDX_W-1:0] rd_idx;
      logic             use_imm;
   } xfer_dec_t;

   function automatic logic fld_match(input logic [19:0] f,
                                      input logic [19:0] mask,
                                      input logic [19:0] val);
      return (f & mask) == val;
   endfunction

endpackage

// File: rtl/psr_xfer_decode.sv
module psr_xfer_decode
   import psr_xfer_pkg::*;
(
   input  logic                 issue_vld,
   input  logic [INSTR_W-1:0]   instr,
   output xfer_dec_t            dec
);

   logic claim;
   logic unused_cond;

   assign unused_cond = ^{instr[31:28], instr[22]};

   always_comb begin
      claim = issue_vld && (instr[27:26] == 2'b00) &&
              (instr[24:23] == 2'b10) && !instr[20];
      dec.kind    = XK_NONE;
      dec.rd_idx  = instr[15:12];
      dec.use_imm = instr[25];
      if (claim) begin
         if (!instr[21]) begin
            if (fld_match(instr[19:0], RD_MASK, RD_VAL) && (instr[15:12] != PC_IDX))
               dec.kind = XK_READ;
            else
               dec.kind = XK_UNDEF;
         end else if (fld_match(instr[19:0], FULL_MASK, FULL_VAL)) begin
            dec.kind = XK_FULL;
         end else if (fld_match(instr[19:0], FLAG_MASK, FLAG_VAL)) begin
            if (!instr[25] && ((instr[3:0] == PC_IDX) || (instr[11:4] != 8'h00)))
               dec.kind = XK_UNDEF;
            else
               dec.kind = XK_FLAG;
         end else begin
            dec.kind = XK_UNDEF;
         end
      end
   end

endmodule

// File: rtl/psr_xfer_merge.sv
module psr_xfer_merge
   import psr_xfer_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NFLAG     = 4,
   parameter int unsigned MODE_W    = 5,
   parameter logic [MODE_W-1:0] USER_MODE = 5'b10000
) (
   input  xfer_dec_t           dec,
   input  logic [DATA_W-1:0]   reg_opnd,
   input  logic [DATA_W-1:0]   imm_opnd,
   input  logic [DATA_W-1:0]   cur_psr,
   input  logic [MODE_W-1:0]   cur_mode,
   output logic                rd_we,
   output logic [IDX_W-1:0]    rd_idx,
   output logic [DATA_W-1:0]   rd_data,
   output logic                fl_we,
   output logic                ct_we,
   output logic [DATA_W-1:0]   wdata,
   output logic                undef
);

   localparam int unsigned CTRL_W = DATA_W - NFLAG;

   logic              is_user;
   logic              keep_ctrl;
   logic [DATA_W-1:0] src;

   always_comb begin
      is_user   = (cur_mode == USER_MODE);
      src       = (dec.kind == XK_FLAG && dec.use_imm) ? imm_opnd : reg_opnd;
      keep_ctrl = (dec.kind == XK_FLAG) || is_user;

      rd_we   = (dec.kind == XK_READ);
      rd_idx  = rd_we ? dec.rd_idx : '0;
      rd_data = rd_we ? cur_psr : '0;

      fl_we = (dec.kind == XK_FULL) || (dec.kind == XK_FLAG);
      ct_we = (dec.kind == XK_FULL) && !is_user;
      if (fl_we)
         wdata = {src[DATA_W-1 -: NFLAG],
                  keep_ctrl ? cur_psr[CTRL_W-1:0] : src[CTRL_W-1:0]};
      else
         wdata = '0;

      undef = (dec.kind == XK_UNDEF);
   end

endmodule

// File: rtl/psr_xfer_stage.sv
module psr_xfer_stage #(
   parameter int unsigned W       = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/psr_xfer_unit.sv
module psr_xfer_unit
   import psr_xfer_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NFLAG     = 4,
   parameter int unsigned MODE_W    = 5,
   parameter logic [MODE_W-1:0] USER_MODE = 5'b10000,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               issue_vld,
   input  logic [31:0]        instr,
   input  logic [DATA_W-1:0]  reg_opnd,
   input  logic [DATA_W-1:0]  imm_opnd,
   input  logic [DATA_W-1:0]  cur_psr,
   input  logic [MODE_W-1:0]  cur_mode,
   output logic               rd_we,
   output logic [3:0]         rd_idx,
   output logic [DATA_W-1:0]  rd_data,
   output logic               psr_we_flags,
   output logic               psr_we_ctrl,
   output logic [DATA_W-1:0]  psr_wdata,
   output logic               undef_pulse
);

   localparam int unsigned BUS_W = 4 + IDX_W + 2 * DATA_W;

   generate
      if (DATA_W < NFLAG + MODE_W) begin : g_bad_width
         $error("psr_xfer_unit: DATA_W too small for flags and mode");
      end
      if (NFLAG != 4) begin : g_bad_flags
         $error("psr_xfer_unit: NFLAG must be 4");
      end
   endgenerate

   xfer_dec_t          dec;
   logic               m_rd_we, m_fl_we, m_ct_we, m_undef;
   logic [IDX_W-1:0]   m_rd_idx;
   logic [DATA_W-1:0]  m_rd_data, m_wdata;
   logic [BUS_W-1:0]   bus_d, bus_q;

   psr_xfer_decode dec_i (
      .issue_vld (issue_vld),
      .instr     (instr),
      .dec       (dec)
   );

   psr_xfer_merge #(
      .DATA_W    (DATA_W),
      .NFLAG     (NFLAG),
      .MODE_W    (MODE_W),
      .USER_MODE (USER_MODE)
   ) merge_i (
      .dec      (dec),
      .reg_opnd (reg_opnd),
      .imm_opnd (imm_opnd),
      .cur_psr  (cur_psr),
      .cur_mode (cur_mode),
      .rd_we    (m_rd_we),
      .rd_idx   (m_rd_idx),
      .rd_data  (m_rd_data),
      .fl_we    (m_fl_we),
      .ct_we    (m_ct_we),
      .wdata    (m_wdata),
      .undef    (m_undef)
   );

   assign bus_d = {m_rd_we, m_rd_idx, m_rd_data, m_fl_we, m_ct_we, m_wdata, m_undef};

   psr_xfer_stage #(
      .W       (BUS_W),
      .OUT_REG (OUT_REG)
   ) stage_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_d),
      .q     (bus_q)
   );

   assign {rd_we, rd_idx, rd_data, psr_we_flags, psr_we_ctrl, psr_wdata, undef_pulse} = bus_q;

endmodule

// File: rtl/psr_xfer_chk.sv
module psr_xfer_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NFLAG     = 4,
   parameter int unsigned MODE_W    = 5,
   parameter logic [MODE_W-1:0] USER_MODE = 5'b10000,
   parameter bit          OUT_REG   = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               issue_vld,
   input logic [31:0]        instr,
   input logic [DATA_W-1:0]  reg_opnd,
   input logic [DATA_W-1:0]  imm_opnd,
   input logic [DATA_W-1:0]  cur_psr,
   input logic [MODE_W-1:0]  cur_mode,
   input logic               rd_we,
   input logic [3:0]         rd_idx,
   input logic [DATA_W-1:0]  rd_data,
   input logic               psr_we_flags,
   input logic               psr_we_ctrl,
   input logic [DATA_W-1:0]  psr_wdata,
   input logic               undef_pulse
);

   localparam int unsigned CTRL_W = DATA_W - NFLAG;

   logic unused_chk;
   assign unused_chk = ^{instr, imm_opnd};

   a_r7_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      undef_pulse |-> !rd_we && !psr_we_flags && !psr_we_ctrl);

   a_r10_no_pc_write: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> rd_idx != 4'hF);

   a_r3_ctrl_needs_flags: assert property (@(posedge clk) disable iff (!rst_n)
      psr_we_ctrl |-> psr_we_flags);

   a_r8_quiet_read_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_we |-> (rd_data == '0) && (rd_idx == 4'h0));

   a_r8_quiet_psr_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !psr_we_flags |-> psr_wdata == '0);

   generate
      if (OUT_REG) begin : g_timed
         a_r1_read_copy: assert property (@(posedge clk) disable iff (!rst_n)
            rd_we |-> rd_data == $past(cur_psr));

         a_r2_full_source: assert property (@(posedge clk) disable iff (!rst_n)
            psr_we_ctrl |-> psr_wdata == $past(reg_opnd));

         a_r3_user_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
            (psr_we_flags && $past(cur_mode) == USER_MODE) |->
               !psr_we_ctrl && psr_wdata[CTRL_W-1:0] == $past(cur_psr[CTRL_W-1:0]));

         a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(issue_vld) |-> !rd_we && !psr_we_flags && !undef_pulse);
      end
   endgenerate

endmodule

bind psr_xfer_unit psr_xfer_chk #(
   .DATA_W    (DATA_W),
   .NFLAG     (NFLAG),
   .MODE_W    (MODE_W),
   .USER_MODE (USER_MODE),
   .OUT_REG   (OUT_REG)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .issue_vld    (issue_vld),
   .instr        (instr),
   .reg_opnd     (reg_opnd),
   .imm_opnd     (imm_opnd),
   .cur_psr      (cur_psr),
   .cur_mode     (cur_mode),
   .rd_we        (rd_we),
   .rd_idx       (rd_idx),
   .rd_data      (rd_data),
   .psr_we_flags (psr_we_flags),
   .psr_we_ctrl  (psr_we_ctrl),
   .psr_wdata    (psr_wdata),
   .undef_pulse  (undef_pulse)
);

// File: tb/psr_xfer_unit_tb.sv
`timescale 1ns/1ps
module psr_xfer_unit_tb_top;

   localparam logic [4:0] USER = 5'b10000;
   localparam logic [4:0] PRIV = 5'b10011;

   typedef struct packed {
      logic        rd_we;
      logic [3:0]  rd_idx;
      logic [31:0] rd_data;
      logic        fw;
      logic        cw;
      logic [31:0] wd;
      logic        und;
   } obs_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_vld = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] reg_opnd = '0;
   logic [31:0] imm_opnd = '0;
   logic [31:0] cur_psr = '0;
   logic [4:0]  cur_mode = PRIV;
   logic        rd_we, psr_we_flags, psr_we_ctrl, undef_pulse;
   logic [3:0]  rd_idx;
   logic [31:0] rd_data, psr_wdata;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int unsigned seq = 0;

   always #2 clk = ~clk;

   psr_xfer_unit dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue_vld    (issue_vld),
      .instr        (instr),
      .reg_opnd     (reg_opnd),
      .imm_opnd     (imm_opnd),
      .cur_psr      (cur_psr),
      .cur_mode     (cur_mode),
      .rd_we        (rd_we),
      .rd_idx       (rd_idx),
      .rd_data      (rd_data),
      .psr_we_flags (psr_we_flags),
      .psr_we_ctrl  (psr_we_ctrl),
      .psr_wdata    (psr_wdata),
      .undef_pulse  (undef_pulse)
   );

   function automatic obs_t observed();
      return '{rd_we, rd_idx, rd_data, psr_we_flags, psr_we_ctrl, psr_wdata, undef_pulse};
   endfunction

   // expected result from the requirement text
   function automatic obs_t model(input logic vld, input logic [31:0] ir,
                                  input logic [31:0] rv, input logic [31:0] iv,
                                  input logic [31:0] ps, input logic [4:0] md,
                                  output string tag);
      obs_t e;
      logic claimed;
      logic [31:0] src;
      e = '0;
      tag = "R8";
      claimed = vld && ir[27:26] == 2'b00 && ir[24:23] == 2'b10 && !ir[20];
      if (claimed) begin
         if (!ir[21]) begin
            if (ir[19:16] == 4'hF && ir[11:0] == 12'h000) begin
               if (ir[15:12] != 4'hF) begin
                  e.rd_we = 1'b1; e.rd_idx = ir[15:12]; e.rd_data = ps; tag = "R1";
               end else begin
                  e.und = 1'b1; tag = "R10 R7";
               end
            end else begin
               e.und = 1'b1; tag = "R6 R7";
            end
         end else if (ir[19:12] == 8'h9F && ir[11:4] == 8'h00) begin
            e.fw = 1'b1;
            if (md == USER) begin
               e.wd = {rv[31:28], ps[27:0]}; tag = "R3";
            end else begin
               e.cw = 1'b1; e.wd = rv; tag = "R2";
            end
         end else if (ir[19:12] == 8'h8F) begin
            if (!ir[25] && (ir[3:0] == 4'hF || ir[11:4] != 8'h00)) begin
               e.und = 1'b1; tag = "R5 R7";
            end else begin
               src = ir[25] ? iv : rv;
               e.fw = 1'b1; e.wd = {src[31:28], ps[27:0]}; tag = "R4";
            end
         end else begin
            e.und = 1'b1; tag = "R6 R7";
         end
      end
      return e;
   endfunction

   task automatic check(input obs_t exp, input string tag);
      obs_t act;
      act = observed();
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s instr=%h actual=%h expected=%h", tag, instr, act, exp);
      end
   endtask

   task automatic step(input logic vld, input logic [31:0] ir, input logic [4:0] md);
      obs_t e;
      string tag;
      seq++;
      issue_vld = vld;
      instr     = ir;
      cur_mode  = md;
      reg_opnd  = (seq * 32'h9E3779B9) ^ 32'h0F0F1234;
      imm_opnd  = (seq * 32'h85EBCA6B) ^ 32'hA5000000;
      cur_psr   = {(seq * 32'hC2B2AE35) >> 5, md} ^ {seq[3:0], 28'h0};
      e = model(vld, ir, reg_opnd, imm_opnd, cur_psr, md, tag);
      @(negedge clk);
      check(e, tag);
   endtask

   function automatic logic [31:0] mk(input logic ib, input logic op,
                                      input logic [7:0] f, input logic [11:0] lo);
      return {4'hE, 2'b00, ib, 2'b10, 1'b0, op, 1'b0, f, lo};
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check('0, "R9 reset");

      // R9: nothing visible before the clock edge that follows the issue
      issue_vld = 1'b1;
      instr     = mk(1'b0, 1'b0, 8'hF3, 12'h000);
      #1;
      check('0, "R9 latency");
      @(negedge clk);
      issue_vld = 1'b0;
      @(negedge clk);

      // main sweep over slot, operand kind, bits[19:12], low field, mode
      for (int op = 0; op < 2; op++)
         for (int ib = 0; ib < 2; ib++)
            for (int f = 0; f < 256; f++)
               for (int l = 0; l < 9; l++)
                  for (int m = 0; m < 2; m++) begin
                     logic [11:0] lo;
                     case (l)
                        0: lo = 12'h000; 1: lo = 12'h007; 2: lo = 12'h00F;
                        3: lo = 12'h010; 4: lo = 12'h017; 5: lo = 12'h01F;
                        6: lo = 12'h800; 7: lo = 12'h807; default: lo = 12'h80F;
                     endcase
                     step(1'b1, mk(ib[0], op[0], f[7:0], lo), m[0] ? USER : PRIV);
                  end

      // R8: unclaimed words and idle issue give no activity
      for (int k = 0; k < 16; k++) begin
         logic [31:0] w;
         w = mk(1'b0, k[0], 8'h9F, 12'h000);
         case (k[3:1])
            3'd0: w[20] = 1'b1;
            3'd1: w[27:26] = 2'b01;
            3'd2: w[27:26] = 2'b10;
            3'd3: w[24:23] = 2'b01;
            3'd4: w[24:23] = 2'b11;
            3'd5: w[24:21] = 4'b0100;
            default: w = mk(1'b0, k[0], 8'hF5, 12'h000);
         endcase
         step(k[3:1] < 3'd6, w, PRIV);
      end

      // R10: read naming register 15 never writes it
      step(1'b1, mk(1'b0, 1'b0, 8'hFF, 12'h000), PRIV);
      // R7: back-to-back undefined words pulse once each, then quiet
      step(1'b1, mk(1'b0, 1'b1, 8'h8F, 12'h00F), USER);
      step(1'b1, mk(1'b0, 1'b1, 8'h12, 12'h000), USER);
      step(1'b0, mk(1'b0, 1'b1, 8'h12, 12'h000), USER);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R9 actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule